// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic and Logic Unit with Product/Quotient Registers

This block evaluates one of twelve operations on two 16-bit operands each clock cycle. A 4-bit operation code selects the operation. The result is registered, so it appears on `result` one clock edge after the operands and code are presented. The block covers addition and subtraction, three kinds of shift, four bitwise functions and a signed less-than test.

Multiply and divide do not use `result`. When the write strobe is high, the unit writes their outputs into a pair of 16-bit holding registers. A multiply fills both registers with the full 32-bit product. A divide puts the quotient in one register and the remainder in the other. A divide by zero leaves both registers as they were and raises an error flag. The flag stays set until reset.

Top module: `twelve_op_alu`

## Requirements
- R1: After a synchronous reset, `result`, `hi`, `lo` and `div_err` are all zero.
- R2: Code 0 (add) gives `a+b` and code 1 (subtract) gives `a-b`, both modulo 2^16, on `result` one cycle after the inputs. Negation is reached by applying nor (code 7) to a value with itself and then adding 1.
- R3: Code 2 shifts `a` left, code 3 shifts it right logically and code 4 shifts it right arithmetically, copying bit 15. Only `b[3:0]` sets the shift amount.
- R4: Code 5 gives and, code 6 gives or, code 7 gives nor and code 8 gives xor of `a` and `b`.
- R5: Code 11 yields 1 when `a` is less than `b` as two's-complement numbers, and 0 otherwise.
- R6: Codes 9 and 10 (multiply, divide) and codes 12 to 15 drive `result` to zero.
- R7: Code 9 with `hilo_we` high loads `{hi,lo}` with the unsigned 32-bit product `a*b`.
- R8: Code 10 with `hilo_we` high and nonzero `b` loads `lo` with the unsigned quotient `a/b` and `hi` with the remainder `a%b`.
- R9: Code 10 with `hilo_we` high and `b` equal to zero leaves `hi` and `lo` unchanged and sets `div_err`. The flag stays at 1 until reset.
- R10: `hi` and `lo` keep their value in every cycle where `hilo_we` is low or the code is neither 9 nor 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| a | input | 16 | First operand |
| b | input | 16 | Second operand; low 4 bits are the shift amount |
| hilo_we | input | 1 | Write strobe for the multiply/divide registers |
| result | output | 16 | Registered operation result |
| hi | output | 16 | Product upper half or divide remainder |
| lo | output | 16 | Product lower half or divide quotient |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
The assertions check several rules on every cycle:
- the holding registers stay stable whenever no valid multiply or divide write occurs;
- a zero-divisor write preserves them and sets the error flag;
- the error flag never clears without reset;
- the compare result is only ever 0 or 1;
- reserved codes yield zero;
- the sum tracks the previous cycle's operands.

The correct arithmetic values themselves are shown only by the bench's directed scenarios:
- shift results for amounts taken from the low bits of `b`, including sign fill;
- full-width products;
- quotient and remainder placement;
- signed ordering across the sign boundary;
- the nor-then-add negation sequence.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SLL  = 4'd2,
    OP_SRL  = 4'd3,
    OP_SRA  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_NOR  = 4'd7,
    OP_XOR  = 4'd8,
    OP_MUL  = 4'd9,
    OP_DIV  = 4'd10,
    OP_SLT  = 4'd11
  } alu_op_e;
endpackage

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
  parameter int WIDTH = 16,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val,
  input  logic [SHW-1:0]   amt,
  output logic [WIDTH-1:0] sll_o,
  output logic [WIDTH-1:0] srl_o,
  output logic [WIDTH-1:0] sra_o
);
  logic signed [WIDTH-1:0] sval;

  always_comb begin
    sval  = $signed(val);
    sll_o = val << amt;
    srl_o = val >> amt;
    sra_o = $unsigned(sval >>> amt);
  end
endmodule

// File: rtl/alu_bitwise_unit.sv
module alu_bitwise_unit #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] nor_o,
  output logic [WIDTH-1:0] xor_o
);
  always_comb begin
    and_o = x & y;
    or_o  = x | y;
    nor_o = ~(x | y);
    xor_o = x ^ y;
  end
endmodule

// File: rtl/alu_muldiv_regs.sv
module alu_muldiv_regs #(
  parameter int WIDTH = 16,
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             is_mul,
  input  logic             is_div,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] hi_q,
  output logic [WIDTH-1:0] lo_q,
  output logic             err_q
);
  logic [PW-1:0]    prod;
  logic [WIDTH-1:0] quo;
  logic [WIDTH-1:0] rem;
  logic             y_zero;

  always_comb begin
    y_zero = (y == '0);
    prod   = PW'(x) * PW'(y);
    quo    = y_zero ? '0 : x / y;
    rem    = y_zero ? '0 : x % y;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      err_q <= 1'b0;
    end else if (we && is_mul) begin
      hi_q <= prod[PW-1:WIDTH];
      lo_q <= prod[WIDTH-1:0];
    end else if (we && is_div) begin
      if (y_zero) begin
        err_q <= 1'b1;
      end else begin
        hi_q <= rem;
        lo_q <= quo;
      end
    end
  end
endmodule

// File: rtl/twelve_op_alu.sv
module twelve_op_alu #(
  parameter int WIDTH = 16,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             hilo_we,
  output logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo,
  output logic             div_err
);
  import alu_pkg::*;

  logic [WIDTH-1:0] sll_w, srl_w, sra_w;
  logic [WIDTH-1:0] and_w, or_w, nor_w, xor_w;
  logic [WIDTH-1:0] next_res;
  logic             is_mul, is_div;

  alu_shift_unit #(.WIDTH(WIDTH)) u_shift (
    .val  (a),
    .amt  (b[SHW-1:0]),
    .sll_o(sll_w),
    .srl_o(srl_w),
    .sra_o(sra_w)
  );

  alu_bitwise_unit #(.WIDTH(WIDTH)) u_bits (
    .x    (a),
    .y    (b),
    .and_o(and_w),
    .or_o (or_w),
    .nor_o(nor_w),
    .xor_o(xor_w)
  );

  always_comb begin
    is_mul = (op == OP_MUL);
    is_div = (op == OP_DIV);
  end

  alu_muldiv_regs #(.WIDTH(WIDTH)) u_md (
    .clk   (clk),
    .rst   (rst),
    .we    (hilo_we),
    .is_mul(is_mul),
    .is_div(is_div),
    .x     (a),
    .y     (b),
    .hi_q  (hi),
    .lo_q  (lo),
    .err_q (div_err)
  );

  always_comb begin
    case (op)
      OP_ADD:  next_res = a + b;
      OP_SUB:  next_res = a - b;
      OP_SLL:  next_res = sll_w;
      OP_SRL:  next_res = srl_w;
      OP_SRA:  next_res = sra_w;
      OP_AND:  next_res = and_w;
      OP_OR:   next_res = or_w;
      OP_NOR:  next_res = nor_w;
      OP_XOR:  next_res = xor_w;
      OP_SLT:  next_res = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
      default: next_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= next_res;
  end
endmodule

// File: rtl/twelve_op_alu_chk.sv
module twelve_op_alu_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             hilo_we,
  input logic [WIDTH-1:0] result,
  input logic [WIDTH-1:0] hi,
  input logic [WIDTH-1:0] lo,
  input logic             div_err
);
  logic prev_rst_q;

  always_ff @(posedge clk) begin
    if (prev_rst_q)
      assert_reset_clear_R1: assert (result == '0 && hi == '0 && lo == '0 && !div_err);
    prev_rst_q <= rst;
  end

  assert_add_sum_R2: assert property (@(posedge clk) disable iff (rst)
    op == 4'd0 |=> result == WIDTH'($past(a) + $past(b)));

  assert_slt_bit_R5: assert property (@(posedge clk) disable iff (rst)
    op == 4'd11 |=> result[WIDTH-1:1] == '0);

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
    op >= 4'd12 |=> result == '0);

  assert_div0_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (hilo_we && op == 4'd10 && b == '0) |=> ($stable(hi) && $stable(lo) && div_err));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    div_err |=> div_err);

  assert_hilo_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(hilo_we && (op == 4'd9 || op == 4'd10)) |=> ($stable(hi) && $stable(lo)));
endmodule

bind twelve_op_alu twelve_op_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op     (op),
  .a      (a),
  .b      (b),
  .hilo_we(hilo_we),
  .result (result),
  .hi     (hi),
  .lo     (lo),
  .div_err(div_err)
);

// File: tb/tb_twelve_op_alu.sv
`timescale 1ns/1ps
module tb_twelve_op_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  op;
  logic [15:0] a, b;
  logic        hilo_we;
  logic [15:0] result, hi, lo;
  logic        div_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  twelve_op_alu dut (
    .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .hilo_we(hilo_we),
    .result(result), .hi(hi), .lo(lo), .div_err(div_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                       input logic we);
    @(negedge clk);
    op = o; a = x; b = y; hilo_we = we;
    @(negedge clk);
    hilo_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op = 4'd0; a = '0; b = '0; hilo_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic test_reset();
    do_reset();
    check("R1 result", {16'h0, result}, 32'h0);
    check("R1 hi/lo", {hi, lo}, 32'h0);
    check("R1 div_err", {31'h0, div_err}, 32'h0);
  endtask

  task automatic test_addsub();
    logic [15:0] x, inv;
    apply(4'd0, 16'h1234, 16'h0F0F, 1'b0);
    check("R2 add", {16'h0, result}, 32'h0000_2143);
    apply(4'd0, 16'hFFFF, 16'h0001, 1'b0);
    check("R2 add wrap", {16'h0, result}, 32'h0);
    apply(4'd1, 16'h0000, 16'h0001, 1'b0);
    check("R2 sub wrap", {16'h0, result}, 32'h0000_FFFF);
    apply(4'd1, 16'h0500, 16'h0123, 1'b0);
    check("R2 sub", {16'h0, result}, 32'h0000_03DD);
    x = 16'h0029;
    apply(4'd7, x, x, 1'b0);
    inv = result;
    apply(4'd0, inv, 16'h0001, 1'b0);
    check("R2 negate", {16'h0, result}, {16'h0, 16'(-x)});
  endtask

  task automatic test_shifts();
    apply(4'd2, 16'h00F1, 16'hFFF3, 1'b0);
    check("R3 sll low bits", {16'h0, result}, 32'h0000_0788);
    apply(4'd3, 16'h8F00, 16'h0014, 1'b0);
    check("R3 srl", {16'h0, result}, 32'h0000_08F0);
    apply(4'd4, 16'h8F00, 16'h0004, 1'b0);
    check("R3 sra neg", {16'h0, result}, 32'h0000_F8F0);
    apply(4'd4, 16'h4F00, 16'h0004, 1'b0);
    check("R3 sra pos", {16'h0, result}, 32'h0000_04F0);
    apply(4'd4, 16'h8000, 16'h000F, 1'b0);
    check("R3 sra max", {16'h0, result}, 32'h0000_FFFF);
  endtask

  task automatic test_logic();
    apply(4'd5, 16'hF0F0, 16'hFF00, 1'b0);
    check("R4 and", {16'h0, result}, 32'h0000_F000);
    apply(4'd6, 16'hF0F0, 16'hFF00, 1'b0);
    check("R4 or", {16'h0, result}, 32'h0000_FFF0);
    apply(4'd7, 16'hF0F0, 16'hFF00, 1'b0);
    check("R4 nor", {16'h0, result}, 32'h0000_000F);
    apply(4'd8, 16'hF0F0, 16'hFF00, 1'b0);
    check("R4 xor", {16'h0, result}, 32'h0000_0FF0);
  endtask

  task automatic test_slt();
    apply(4'd11, 16'hFFFF, 16'h0001, 1'b0);
    check("R5 neg<pos", {16'h0, result}, 32'h1);
    apply(4'd11, 16'h0001, 16'hFFFF, 1'b0);
    check("R5 pos<neg", {16'h0, result}, 32'h0);
    apply(4'd11, 16'h0042, 16'h0042, 1'b0);
    check("R5 equal", {16'h0, result}, 32'h0);
    apply(4'd11, 16'h8000, 16'h7FFF, 1'b0);
    check("R5 extremes", {16'h0, result}, 32'h1);
  endtask

  task automatic test_zero_codes();
    for (int c = 12; c < 16; c++) begin
      apply(4'(c), 16'hABCD, 16'h1234, 1'b0);
      check("R6 reserved", {16'h0, result}, 32'h0);
    end
    apply(4'd9, 16'h0003, 16'h0004, 1'b1);
    check("R6 mul result", {16'h0, result}, 32'h0);
  endtask

  task automatic test_muldiv();
    apply(4'd9, 16'hFFFF, 16'hFFFF, 1'b1);
    check("R7 mul max", {hi, lo}, 32'hFFFE_0001);
    apply(4'd9, 16'h1234, 16'h0010, 1'b1);
    check("R7 mul", {hi, lo}, 32'h0001_2340);
    apply(4'd10, 16'd100, 16'd7, 1'b1);
    check("R8 div", {hi, lo}, {16'd2, 16'd14});
    check("R6 div result", {16'h0, result}, 32'h0);
    apply(4'd10, 16'hFFFF, 16'h0002, 1'b1);
    check("R8 div unsigned", {hi, lo}, {16'h0001, 16'h7FFF});
  endtask

  task automatic test_hold();
    apply(4'd9, 16'h0002, 16'h0003, 1'b0);
    check("R10 mul no we", {hi, lo}, {16'h0001, 16'h7FFF});
    apply(4'd0, 16'h0002, 16'h0003, 1'b1);
    check("R10 add with we", {hi, lo}, {16'h0001, 16'h7FFF});
  endtask

  task automatic test_div_zero();
    check("R9 err clear before", {31'h0, div_err}, 32'h0);
    apply(4'd10, 16'h1111, 16'h0000, 1'b1);
    check("R9 hilo kept", {hi, lo}, {16'h0001, 16'h7FFF});
    check("R9 err set", {31'h0, div_err}, 32'h1);
    apply(4'd10, 16'd9, 16'd4, 1'b1);
    check("R9 err sticky", {31'h0, div_err}, 32'h1);
    check("R8 div after err", {hi, lo}, {16'd1, 16'd2});
    do_reset();
    check("R1 err cleared", {31'h0, div_err}, 32'h0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    rst = 1'b1; op = '0; a = '0; b = '0; hilo_we = 1'b0;
    test_reset();
    test_addsub();
    test_shifts();
    test_logic();
    test_slt();
    test_zero_codes();
    test_muldiv();
    test_hold();
    test_div_zero();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end
endmodule